// File: doc/BRIEF.md
# PWM Output Steering Unit

This block sits after an existing PWM generator. It takes the generator's single modulated waveform and a one-cycle strobe that marks the start of each PWM period. It then decides, pin by pin, which of four outputs (A, B, C and D) carries that waveform. Any pin that is not steered carries the matching bit of a general-purpose port data word. The waveform on each steered pin can be active-high or active-low, as chosen by a two-bit polarity input.

Software sets the routing through an 8-bit control register, which it writes and reads back over a plain register port. New enables can take effect at once, or they can wait in a pending state until the next period strobe, so that no period is cut short on the pins. A separate alternating mode ignores the enables and moves the waveform between pins A and B on every new period. When the mode input says the generator is not running single-output PWM, the unit passes the generator's own pin values through untouched.

All pins are plain control and data wires. None of them is a stream, so there is no valid/ready handshake and no back-pressure. A register write is accepted on every clock edge where `cfg_we` is high.

Top module: `pwm_steer_unit`

## Requirements
- R1: After reset the control register reads 0x01, so only pin A is steered and pins B, C and D show their port data bits.
- R2: With alternating mode off, a pin whose enable is 1 carries the polarity-adjusted PWM waveform, and a pin whose enable is 0 carries its `port_data` bit. Enable bits are register bit 0 for A, bit 1 for B, bit 2 for C and bit 3 for D.
- R3: `pol_mode[1]`=1 inverts the waveform on pins A and C, and `pol_mode[0]`=1 inverts it on pins B and D.
- R4: A write with register bit 4 (sync) = 0 applies its enables on the pins right after the clock edge that captures the write.
- R5: A write with sync = 1 leaves the active enables unchanged until the next `period_start` cycle. A write made in the same cycle as `period_start` is applied at that same boundary.
- R6: When register bits 7-6 are nonzero, the enables are ignored. Pin A carries the waveform from mode entry through the first period. Each later `period_start` swaps the waveform between A and B. The idle pin of the pair holds its inactive level (1 if inverted, else 0), and pins C and D show port data.
- R7: When `single_pwm_mode` is 0, `pin_out` equals `native_out`.
- R8: Readback returns the last written value with bit 5 forced to 0, even while the enables are still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register readback |
| pwm_in | input | 1 | Modulated waveform from the PWM generator |
| period_start | input | 1 | One-cycle strobe at the start of each PWM period |
| single_pwm_mode | input | 1 | 1 when the generator runs single-output PWM, which enables steering |
| pol_mode | input | 2 | Polarity select: bit 1 for pins A and C, bit 0 for pins B and D |
| port_data | input | 4 | General-purpose data bits for pins D..A |
| native_out | input | 4 | Generator's own pin values, used when steering is off |
| pin_out | output | 4 | Output pins D..A |

## Verification
The assertions check several properties on every cycle: bit 5 of the readback stays 0, the active enables stay unchanged except on an immediate write or a period strobe, the A/B selection flips at every strobe once alternation is running, and pins C and D follow port data while alternating. The bench scenarios are needed to show the rest: the actual pin values for each mix of enables, polarity and waveform level, the exact cycle in which a deferred write appears, the A-first order of alternation, and the bypass of the native pin values.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int NPINS    = 4;
  localparam int CTRL_W   = 8;
  localparam int SYNC_BIT = 4;
  localparam int RSV_BIT  = 5;
  localparam int ALT_LO   = 6;
  localparam int ALT_HI   = 7;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h01;
  localparam logic [CTRL_W-1:0] CTRL_WMASK = ~(8'h01 << RSV_BIT);

  typedef logic [NPINS-1:0] pinvec_t;
endpackage

// File: rtl/steer_ctrl_reg.sv
module steer_ctrl_reg
  import steer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              period_start,
  output logic [CTRL_W-1:0] reg_q,
  output pinvec_t           en_act
);
  logic    wr_now;
  pinvec_t en_next;

  assign wr_now  = we && !wdata[SYNC_BIT];
  assign en_next = we ? wdata[NPINS-1:0] : reg_q[NPINS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q  <= CTRL_RESET;
      en_act <= CTRL_RESET[NPINS-1:0];
    end else begin
      if (we) reg_q <= wdata & CTRL_WMASK;
      if (wr_now)            en_act <= wdata[NPINS-1:0];
      else if (period_start) en_act <= en_next;
    end
  end

  p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q[RSV_BIT] == 1'b0);

  p_hold_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_start && !wr_now) |=> $stable(en_act));

  p_reset_val_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (reg_q == CTRL_RESET && en_act == 4'b0001));
endmodule

// File: rtl/steer_alt_tracker.sv
module steer_alt_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic alt_on,
  input  logic period_start,
  output logic sel_b
);
  logic started;

  always_ff @(posedge clk) begin
    if (!rst_n || !alt_on) begin
      started <= 1'b0;
      sel_b   <= 1'b0;
    end else if (period_start) begin
      if (started) sel_b <= ~sel_b;
      else begin
        started <= 1'b1;
        sel_b   <= 1'b0;
      end
    end
  end

  p_first_is_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !sel_b);

  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_on && started && period_start) |=> (!alt_on || sel_b != $past(sel_b)));
endmodule

// File: rtl/steer_pin_mux.sv
module steer_pin_mux
  import steer_pkg::*;
(
  input  logic    pwm_in,
  input  logic    steer_on,
  input  logic    alt_on,
  input  logic    sel_b,
  input  logic [1:0] pol_mode,
  input  pinvec_t en_act,
  input  pinvec_t port_data,
  input  pinvec_t native_out,
  output pinvec_t pin_out
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam bit IS_AC = (i % 2) == 0;
    logic inv, wave, alt_drive;

    assign inv  = IS_AC ? pol_mode[1] : pol_mode[0];
    assign wave = pwm_in ^ inv;

    if (i == 0) begin : g_alt_a
      assign alt_drive = sel_b ? inv : wave;
    end else if (i == 1) begin : g_alt_b
      assign alt_drive = sel_b ? wave : inv;
    end else begin : g_alt_port
      assign alt_drive = port_data[i];
    end

    always_comb begin
      if (!steer_on)      pin_out[i] = native_out[i];
      else if (alt_on)    pin_out[i] = alt_drive;
      else if (en_act[i]) pin_out[i] = wave;
      else                pin_out[i] = port_data[i];
    end
  end
endmodule

// File: rtl/pwm_steer_unit.sv
module pwm_steer_unit
  import steer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        pwm_in,
  input  logic        period_start,
  input  logic        single_pwm_mode,
  input  logic [1:0]  pol_mode,
  input  logic [3:0]  port_data,
  input  logic [3:0]  native_out,
  output logic [3:0]  pin_out
);
  logic [CTRL_W-1:0] reg_q;
  pinvec_t           en_act;
  logic              alt_on;
  logic              sel_b;

  steer_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .period_start(period_start), .reg_q(reg_q), .en_act(en_act)
  );

  assign alt_on    = |reg_q[ALT_HI:ALT_LO];
  assign cfg_rdata = reg_q;

  steer_alt_tracker u_alt (
    .clk(clk), .rst_n(rst_n), .alt_on(alt_on),
    .period_start(period_start), .sel_b(sel_b)
  );

  steer_pin_mux u_mux (
    .pwm_in(pwm_in), .steer_on(single_pwm_mode), .alt_on(alt_on),
    .sel_b(sel_b), .pol_mode(pol_mode), .en_act(en_act),
    .port_data(port_data), .native_out(native_out), .pin_out(pin_out)
  );

  p_alt_cd_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (single_pwm_mode && alt_on) |-> pin_out[3:2] == port_data[3:2]);

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !single_pwm_mode |-> pin_out == native_out);
endmodule

// File: tb/pwm_steer_unit_test.sv
module pwm_steer_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {enables[14:11], pol[10:9], pwm[8], port[7:4], expected[3:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {4'b0101, 2'b00, 1'b1, 4'b0000, 4'b0101},
    {4'b0101, 2'b00, 1'b0, 4'b1010, 4'b1010},
    {4'b1111, 2'b10, 1'b1, 4'b0000, 4'b1010},
    {4'b1111, 2'b01, 1'b1, 4'b0000, 4'b0101},
    {4'b0011, 2'b11, 1'b0, 4'b0000, 4'b0011},
    {4'b0000, 2'b11, 1'b1, 4'b0110, 4'b0110},
    {4'b1000, 2'b00, 1'b1, 4'b0001, 4'b1001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, pwm_in = 1'b0, period_start = 1'b0, single_pwm_mode = 1'b1;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic [1:0] pol_mode = '0;
  logic [3:0] port_data = '0, native_out = '0, pin_out;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_steer_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pwm_in(pwm_in), .period_start(period_start),
    .single_pwm_mode(single_pwm_mode), .pol_mode(pol_mode),
    .port_data(port_data), .native_out(native_out), .pin_out(pin_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic strobe();
    period_start = 1'b1;
    @(negedge clk);
    period_start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset routing
    chk("R1 readback", cfg_rdata, 8'h01);
    pwm_in = 1'b1; port_data = 4'b1110; #1;
    chk("R1 pins", {4'b0, pin_out}, 8'h0F);
    port_data = 4'b0000; #1;
    chk("R1 pins port", {4'b0, pin_out}, 8'h01);

    // R2/R3/R4 vector table, immediate writes
    for (int i = 0; i < NVEC; i++) begin
      pol_mode = VEC[i][10:9]; pwm_in = VEC[i][8]; port_data = VEC[i][7:4];
      wr({4'b0000, VEC[i][14:11]});
      chk($sformatf("R2 R3 R4 vec%0d", i), {4'b0, pin_out}, {4'b0, VEC[i][3:0]});
    end

    // R5 / R8 deferred update
    pol_mode = 2'b00; pwm_in = 1'b1; port_data = 4'b0000;
    wr(8'h01);
    wr(8'h3C);
    chk("R8 readback bit5 cleared", cfg_rdata, 8'h1C);
    chk("R5 held before period", {4'b0, pin_out}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R5 still held", {4'b0, pin_out}, 8'h01);
    strobe();
    chk("R5 applied at period", {4'b0, pin_out}, 8'h0C);
    // write in the same cycle as the strobe
    cfg_we = 1'b1; cfg_wdata = 8'h12; period_start = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; period_start = 1'b0;
    chk("R5 same-cycle write", {4'b0, pin_out}, 8'h02);

    // R6 alternation
    wr(8'h4F);
    pwm_in = 1'b1; port_data = 4'b1000;
    #1 chk("R6 entry drives A", {4'b0, pin_out}, 8'h09);
    strobe();
    chk("R6 first period A", {4'b0, pin_out}, 8'h09);
    strobe();
    chk("R6 second period B", {4'b0, pin_out}, 8'h0A);
    strobe();
    chk("R6 third period A", {4'b0, pin_out}, 8'h09);
    pol_mode = 2'b11; strobe(); pwm_in = 1'b0; #1;
    chk("R6 inverted B, idle A high", {4'b0, pin_out}, 8'h0B);
    pwm_in = 1'b1; #1;
    chk("R6 inverted B low, idle A high", {4'b0, pin_out}, 8'h09);

    // R7 bypass
    single_pwm_mode = 1'b0; native_out = 4'b0110; #1;
    chk("R7 bypass", {4'b0, pin_out}, 8'h06);
    native_out = 4'b1001; #1;
    chk("R7 bypass follows native", {4'b0, pin_out}, 8'h09);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule